// File: doc/BRIEF.md
# Programmable Video Blanking Generator

This block derives horizontal and vertical blanking pulses for a display video path from the deflection timing signals. It runs on the pixel clock and watches three asynchronous timing inputs: a horizontal flyback reference, a logic-level vertical sync and a clamp pulse. It also receives a horizontal sync input, which can stand in for the clamp pulse. Every timing input is resynchronised through a two-flop chain. Rising and falling edges are found on the resynchronised levels.

Horizontal blanking is predictive. The block counts pixel clocks between successive flyback rising edges to learn the line period. It then raises horizontal blanking a programmable number of pixels before the next expected flyback edge, and drops it when flyback falls. Vertical blanking starts on the leading edge of vertical sync and lasts for a programmed number of lines. Lines are counted on flyback rising edges. Each blanking output has its own enable, and a combined blank output merges the two gated pulses.

The block has no streaming data path. All of its pins are plain timing and configuration levels, so there is no valid/ready handshake and no back-pressure to honour.

Top module: `blank_pulse_gen`

## Requirements
- R1: `clamp_o` follows the resynchronised `clamp_i` when `cfg_clamp_sel` is 0 and the resynchronised `hsync_i` when it is 1. A level change on the selected input appears on `clamp_o` after two rising clock edges. The unselected input has no effect.
- R2: Until two flyback rising edges have been seen since reset, `hblank_o` rises on the third rising clock edge after `flyback_i` rises, whatever the advance setting.
- R3: Once the period is known, `hblank_o` rises `A` clock edges before the third rising edge that follows the predicted flyback rise. `A` is `cfg_hadv`, and values above 64 act as 64.
- R4: `hblank_o` falls on the third rising clock edge after `flyback_i` falls.
- R5: `vblank_o` rises on the third rising clock edge after `vsync_i` rises. It falls on the third rising clock edge after the N-th later flyback rising edge, where N is the line setting.
- R6: The line setting `cfg_vlines` is taken as 3 when below 3 and as 127 when above 127.
- R7: Only the rising edge of `vsync_i` matters. Its high time and its falling edge have no effect on `vblank_o`.
- R8: A `vsync_i` rising edge during active vertical blanking restarts the line count from zero, and `vblank_o` stays high without a gap.
- R9: A flyback rising edge detected in the same cycle as a vertical sync rising edge is not counted as a line.
- R10: With `cfg_hblank_en` low, `hblank_o` stays 0. With `cfg_vblank_en` low, `vblank_o` stays 0.
- R11: `blank_o` is high exactly when `hblank_o` or `vblank_o` is high.
- R12: While `rst_n` is low, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| flyback_i | input | 1 | Horizontal flyback reference, asynchronous |
| vsync_i | input | 1 | Vertical sync, logic level, asynchronous |
| hsync_i | input | 1 | Horizontal sync, alternative clamp source |
| clamp_i | input | 1 | Dedicated clamp pulse input |
| cfg_vlines | input | VLINES_W (8) | Vertical blanking length in lines |
| cfg_hadv | input | HADV_W (7) | Horizontal blanking advance in pixels |
| cfg_hblank_en | input | 1 | Horizontal blanking enable |
| cfg_vblank_en | input | 1 | Vertical blanking enable |
| cfg_clamp_sel | input | 1 | 1 selects hsync_i as clamp source |
| hblank_o | output | 1 | Horizontal blanking pulse |
| vblank_o | output | 1 | Vertical blanking pulse |
| blank_o | output | 1 | Combined blanking |
| clamp_o | output | 1 | Selected, resynchronised clamp pulse |

## Verification
A vertical sync edge can land in the same cycle as a flyback rising edge. In that cycle the sync edge restarts the line count while the flyback edge asks to advance it. The bench provokes this by driving both inputs high on the same clock, so both pass through identical synchronisers and are detected together. It judges the outcome by the clock edge on which `vblank_o` falls: that edge must come one full line later than it would if the coincident edge had been counted. A second collision, a new sync edge during active blanking, is judged the same way against the cycle that a non-restarting count would give.

// File: rtl/blank_pkg.sv
package blank_pkg;
  localparam int VLINE_MIN   = 3;
  localparam int VLINE_MAX   = 127;
  localparam int VLINE_CNT_W = $clog2(VLINE_MAX + 1);
  localparam int HADV_MAX    = 64;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/bpg_sync.sv
module bpg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bpg_hblank.sv
module bpg_hblank
  import blank_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int ADV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  edge_t            fb,
  input  logic [ADV_W-1:0] cfg_adv,
  output logic             hb_raw
);
  localparam int TW = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [TW-1:0]    ADV_CAP = TW'(HADV_MAX);

  logic [CNT_W-1:0] pix_cnt;
  logic [CNT_W-1:0] period;
  logic [1:0]       seen;
  logic             valid;
  logic [TW-1:0]    adv_ext, adv_eff, target, next_pos;
  logic             early_hit;

  assign valid = seen[1];

  always_comb begin
    adv_ext   = TW'(cfg_adv);
    adv_eff   = (adv_ext > ADV_CAP) ? ADV_CAP : adv_ext;
    target    = {1'b0, period} - adv_eff;
    next_pos  = {1'b0, pix_cnt} + TW'(1);
    early_hit = valid && (adv_eff != '0) && !target[TW-1] &&
                (target != '0) && (next_pos == target);
  end

  // Period learning: clocks between consecutive flyback rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_cnt <= '0;
      period  <= '0;
      seen    <= '0;
    end else if (fb.rise) begin
      pix_cnt <= '0;
      period  <= (pix_cnt == CNT_MAX) ? CNT_MAX : pix_cnt + CNT_W'(1);
      if (seen != 2'd2) seen <= seen + 2'd1;
    end else if (pix_cnt != CNT_MAX) begin
      pix_cnt <= pix_cnt + CNT_W'(1);
    end
  end

  // Blank state: flyback rise sets, flyback fall clears, prediction sets early
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hb_raw <= 1'b0;
    else if (fb.rise)   hb_raw <= 1'b1;
    else if (fb.fall)   hb_raw <= 1'b0;
    else if (early_hit) hb_raw <= 1'b1;
  end
endmodule

// File: rtl/bpg_vblank.sv
module bpg_vblank
  import blank_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   vs_rise,
  input  logic                   fb_rise,
  input  logic [CFG_W-1:0]       cfg_lines,
  output logic                   vb_raw,
  output logic [VLINE_CNT_W-1:0] line_cnt
);
  localparam int LW = (CFG_W > VLINE_CNT_W) ? CFG_W : VLINE_CNT_W;

  logic [LW-1:0]          cfg_ext, clamped;
  logic [VLINE_CNT_W-1:0] lines_eff;
  logic [VLINE_CNT_W:0]   next_cnt;

  always_comb begin
    cfg_ext = LW'(cfg_lines);
    if (cfg_ext < LW'(VLINE_MIN))      clamped = LW'(VLINE_MIN);
    else if (cfg_ext > LW'(VLINE_MAX)) clamped = LW'(VLINE_MAX);
    else                               clamped = cfg_ext;
    lines_eff = VLINE_CNT_W'(clamped);
    next_cnt  = {1'b0, line_cnt} + (VLINE_CNT_W + 1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vb_raw   <= 1'b0;
      line_cnt <= '0;
    end else if (vs_rise) begin
      vb_raw   <= 1'b1;
      line_cnt <= '0;
    end else if (vb_raw && fb_rise) begin
      if (next_cnt >= {1'b0, lines_eff}) begin
        vb_raw   <= 1'b0;
        line_cnt <= '0;
      end else begin
        line_cnt <= next_cnt[VLINE_CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/blank_pulse_gen.sv
module blank_pulse_gen
  import blank_pkg::*;
#(
  parameter int PIX_CNT_W   = 12,
  parameter int HADV_W      = 7,
  parameter int VLINES_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flyback_i,
  input  logic                vsync_i,
  input  logic                hsync_i,
  input  logic                clamp_i,
  input  logic [VLINES_W-1:0] cfg_vlines,
  input  logic [HADV_W-1:0]   cfg_hadv,
  input  logic                cfg_hblank_en,
  input  logic                cfg_vblank_en,
  input  logic                cfg_clamp_sel,
  output logic                hblank_o,
  output logic                vblank_o,
  output logic                blank_o,
  output logic                clamp_o
);
  localparam int NUM_IN = 4;
  localparam int IX_FB  = 0;
  localparam int IX_VS  = 1;
  localparam int IX_HS  = 2;
  localparam int IX_CL  = 3;

  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] lvl;
  logic fb_prev, vs_prev;
  logic fb_rise, fb_fall, vs_rise;
  edge_t fb_edge;
  logic hb_raw, vb_raw;
  logic [VLINE_CNT_W-1:0] vline_cnt;

  assign raw_in = {clamp_i, hsync_i, vsync_i, flyback_i};

  for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
    bpg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_in[i]),
      .q    (lvl[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_prev <= 1'b0;
      vs_prev <= 1'b0;
    end else begin
      fb_prev <= lvl[IX_FB];
      vs_prev <= lvl[IX_VS];
    end
  end

  assign fb_rise      = lvl[IX_FB] & ~fb_prev;
  assign fb_fall      = ~lvl[IX_FB] & fb_prev;
  assign vs_rise      = lvl[IX_VS] & ~vs_prev;
  assign fb_edge.rise = fb_rise;
  assign fb_edge.fall = fb_fall;

  bpg_hblank #(.CNT_W(PIX_CNT_W), .ADV_W(HADV_W)) u_hblank (
    .clk    (clk),
    .rst_n  (rst_n),
    .fb     (fb_edge),
    .cfg_adv(cfg_hadv),
    .hb_raw (hb_raw)
  );

  bpg_vblank #(.CFG_W(VLINES_W)) u_vblank (
    .clk      (clk),
    .rst_n    (rst_n),
    .vs_rise  (vs_rise),
    .fb_rise  (fb_rise),
    .cfg_lines(cfg_vlines),
    .vb_raw   (vb_raw),
    .line_cnt (vline_cnt)
  );

  assign hblank_o = hb_raw & cfg_hblank_en;
  assign vblank_o = vb_raw & cfg_vblank_en;
  assign blank_o  = hblank_o | vblank_o;
  assign clamp_o  = cfg_clamp_sel ? lvl[IX_HS] : lvl[IX_CL];
endmodule

// File: rtl/blank_pulse_chk.sv
module blank_pulse_chk #(
  parameter int LCW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fb_rise,
  input logic           fb_fall,
  input logic           vs_rise,
  input logic           hb_raw,
  input logic           vb_raw,
  input logic [LCW-1:0] line_cnt
);
  assert_hb_on_flyback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rise |=> hb_raw);

  assert_hb_off_flyback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fb_fall |=> !hb_raw);

  assert_vb_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> vb_raw);

  assert_vb_idle_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !vb_raw |-> (line_cnt == '0));

  assert_vb_len_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vb_raw |-> (line_cnt < LCW'(127)));

  assert_vb_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_rise && vb_raw) |=> (vb_raw && line_cnt == '0));

  assert_vb_coincide_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_rise && fb_rise) |=> (vb_raw && line_cnt == '0));
endmodule

bind blank_pulse_gen blank_pulse_chk #(.LCW(blank_pkg::VLINE_CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .fb_rise (fb_rise),
  .fb_fall (fb_fall),
  .vs_rise (vs_rise),
  .hb_raw  (hb_raw),
  .vb_raw  (vb_raw),
  .line_cnt(vline_cnt)
);

// File: tb/blank_pulse_gen_tb.sv
module blank_pulse_gen_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       flyback_i = 1'b0, vsync_i = 1'b0, hsync_i = 1'b0, clamp_i = 1'b0;
  logic [7:0] cfg_vlines = 8'd10;
  logic [6:0] cfg_hadv = 7'd0;
  logic       cfg_hblank_en = 1'b1, cfg_vblank_en = 1'b1, cfg_clamp_sel = 1'b0;
  logic       hblank_o, vblank_o, blank_o, clamp_o;

  blank_pulse_gen u_dut (
    .clk(clk), .rst_n(rst_n), .flyback_i(flyback_i), .vsync_i(vsync_i),
    .hsync_i(hsync_i), .clamp_i(clamp_i), .cfg_vlines(cfg_vlines),
    .cfg_hadv(cfg_hadv), .cfg_hblank_en(cfg_hblank_en),
    .cfg_vblank_en(cfg_vblank_en), .cfg_clamp_sel(cfg_clamp_sel),
    .hblank_o(hblank_o), .vblank_o(vblank_o), .blank_o(blank_o), .clamp_o(clamp_o)
  );

  localparam int HR = 0, HF = 1, VR = 2, VF = 3;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  int ev [4][0:1023];
  int ecnt [4];
  int rc [0:255];
  int vs_c = 0;
  int blank_bad = 0;
  bit blank_h_only = 0, blank_v_only = 0;
  logic hb_q = 1'b0, vb_q = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int find_ev(input int k, input int c);
    for (int i = 0; i < ecnt[k]; i++) if (ev[k][i] == c) return c;
    return -1;
  endfunction

  task automatic push(input int k);
    if (ecnt[k] < 1024) begin
      ev[k][ecnt[k]] = cyc;
      ecnt[k]++;
    end
  endtask

  task automatic tick;
    @(negedge clk);
    cyc++;
    if (hblank_o && !hb_q) push(HR);
    if (!hblank_o && hb_q) push(HF);
    if (vblank_o && !vb_q) push(VR);
    if (!vblank_o && vb_q) push(VF);
    if (blank_o !== (hblank_o | vblank_o)) blank_bad++;
    if (blank_o && hblank_o && !vblank_o) blank_h_only = 1;
    if (blank_o && vblank_o && !hblank_o) blank_v_only = 1;
    hb_q = hblank_o;
    vb_q = vblank_o;
  endtask

  task automatic clear_ev;
    for (int k = 0; k < 4; k++) ecnt[k] = 0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    flyback_i = 1'b0; vsync_i = 1'b0; hsync_i = 1'b0; clamp_i = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    clear_ev();
  endtask

  task automatic idle(input int n);
    flyback_i = 1'b0;
    repeat (n) tick();
  endtask

  // Lines of period p with flyback high for h clocks; optional vsync pulse
  task automatic drive_lines(input int n, input int p, input int h,
                             input int vs_line, input int vs_off, input int vs_len);
    int vs_left = 0;
    for (int l = 0; l < n; l++) begin
      for (int i = 0; i < p; i++) begin
        tick();
        flyback_i = (i < h);
        if (i == 0) rc[l] = cyc;
        if (vs_left > 0) begin
          vs_left--;
          if (vs_left == 0) vsync_i = 1'b0;
        end
        if (l == vs_line && i == vs_off) begin
          vsync_i = 1'b1;
          vs_c = cyc;
          vs_left = vs_len;
        end
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    flyback_i = 1'b1; vsync_i = 1'b1; clamp_i = 1'b1; hsync_i = 1'b1;
    repeat (4) tick();
    check(hblank_o == 0, "R12 hblank in reset", hblank_o, 0);
    check(vblank_o == 0, "R12 vblank in reset", vblank_o, 0);
    check(blank_o == 0, "R12 blank in reset", blank_o, 0);
    check(clamp_o == 0, "R12 clamp in reset", clamp_o, 0);
    do_reset();
  endtask

  task automatic t_hblank_cold;
    do_reset();
    cfg_hadv = 7'd8;
    drive_lines(4, 40, 6, -1, 0, 0);
    idle(6);
    check(find_ev(HR, rc[0] + 3) == rc[0] + 3, "R2 first line start", find_ev(HR, rc[0] + 3), rc[0] + 3);
    check(find_ev(HR, rc[1] + 3) == rc[1] + 3, "R2 second line start", find_ev(HR, rc[1] + 3), rc[1] + 3);
    check(find_ev(HR, rc[2] - 5) == rc[2] - 5, "R3 advance 8", find_ev(HR, rc[2] - 5), rc[2] - 5);
    check(find_ev(HF, rc[0] + 9) == rc[0] + 9, "R4 end line 0", find_ev(HF, rc[0] + 9), rc[0] + 9);
    check(find_ev(HF, rc[3] + 9) == rc[3] + 9, "R4 end line 3", find_ev(HF, rc[3] + 9), rc[3] + 9);
  endtask

  task automatic t_hadv_bounds;
    do_reset();
    cfg_hadv = 7'd0;
    drive_lines(4, 100, 10, -1, 0, 0);
    check(find_ev(HR, rc[3] + 3) == rc[3] + 3, "R3 advance 0", find_ev(HR, rc[3] + 3), rc[3] + 3);
    cfg_hadv = 7'd64;
    drive_lines(4, 100, 10, -1, 0, 0);
    check(find_ev(HR, rc[1] - 61) == rc[1] - 61, "R3 advance 64", find_ev(HR, rc[1] - 61), rc[1] - 61);
    check(find_ev(HR, rc[3] - 61) == rc[3] - 61, "R3 advance 64 later", find_ev(HR, rc[3] - 61), rc[3] - 61);
    cfg_hadv = 7'd100;
    drive_lines(4, 100, 10, -1, 0, 0);
    idle(5);
    check(find_ev(HR, rc[2] - 61) == rc[2] - 61, "R3 advance capped", find_ev(HR, rc[2] - 61), rc[2] - 61);
    cfg_hadv = 7'd0;
  endtask

  task automatic t_vblank_basic;
    do_reset();
    cfg_vlines = 8'd5;
    drive_lines(8, 20, 3, 0, 10, 4);
    idle(5);
    check(find_ev(VR, vs_c + 3) == vs_c + 3, "R5 vblank start", find_ev(VR, vs_c + 3), vs_c + 3);
    check(find_ev(VF, rc[5] + 3) == rc[5] + 3, "R5 vblank end", find_ev(VF, rc[5] + 3), rc[5] + 3);
    check(ecnt[VF] == 1, "R5 single end", ecnt[VF], 1);
  endtask

  task automatic t_vsync_long;
    do_reset();
    cfg_vlines = 8'd3;
    drive_lines(10, 20, 3, 0, 5, 120);
    idle(5);
    check(find_ev(VF, rc[3] + 3) == rc[3] + 3, "R7 end with sync high", find_ev(VF, rc[3] + 3), rc[3] + 3);
    check(ecnt[VR] == 1, "R7 sync fall no retrigger", ecnt[VR], 1);
  endtask

  task automatic t_vlines_clamp;
    do_reset();
    cfg_vlines = 8'd1;
    drive_lines(8, 20, 3, 0, 5, 2);
    idle(5);
    check(find_ev(VF, rc[3] + 3) == rc[3] + 3, "R6 setting 1 acts as 3", find_ev(VF, rc[3] + 3), rc[3] + 3);
    do_reset();
    cfg_vlines = 8'd0;
    drive_lines(8, 20, 3, 0, 5, 2);
    idle(5);
    check(find_ev(VF, rc[3] + 3) == rc[3] + 3, "R6 setting 0 acts as 3", find_ev(VF, rc[3] + 3), rc[3] + 3);
    do_reset();
    cfg_vlines = 8'd200;
    drive_lines(130, 12, 2, 0, 5, 2);
    idle(5);
    check(find_ev(VF, rc[127] + 3) == rc[127] + 3, "R6 setting 200 acts as 127", find_ev(VF, rc[127] + 3), rc[127] + 3);
  endtask

  task automatic t_restart;
    do_reset();
    cfg_vlines = 8'd6;
    drive_lines(3, 20, 3, 0, 5, 2);
    drive_lines(11, 20, 3, 2, 5, 2);
    idle(5);
    check(find_ev(VF, rc[8] + 3) == rc[8] + 3, "R8 restart end", find_ev(VF, rc[8] + 3), rc[8] + 3);
    check(ecnt[VR] == 1 && ecnt[VF] == 1, "R8 no gap", ecnt[VR] + ecnt[VF], 2);
  endtask

  task automatic t_coincide;
    do_reset();
    cfg_vlines = 8'd3;
    drive_lines(8, 20, 3, 1, 0, 2);
    idle(5);
    check(vs_c == rc[1], "R9 stimulus aligned", vs_c, rc[1]);
    check(find_ev(VF, rc[4] + 3) == rc[4] + 3, "R9 coincident rise not counted", find_ev(VF, rc[4] + 3), rc[4] + 3);
  endtask

  task automatic t_enables;
    do_reset();
    cfg_vlines = 8'd4;
    cfg_hblank_en = 1'b0;
    cfg_vblank_en = 1'b0;
    drive_lines(6, 20, 3, 0, 5, 2);
    idle(5);
    check(ecnt[HR] == 0, "R10 hblank disabled", ecnt[HR], 0);
    check(ecnt[VR] == 0, "R10 vblank disabled", ecnt[VR], 0);
    cfg_hblank_en = 1'b1;
    drive_lines(4, 20, 3, 0, 5, 2);
    idle(5);
    check(ecnt[HR] > 0, "R10 hblank enabled", ecnt[HR], 1);
    check(ecnt[VR] == 0, "R10 vblank still disabled", ecnt[VR], 0);
    cfg_vblank_en = 1'b1;
  endtask

  task automatic t_blank_or;
    check(blank_bad == 0, "R11 blank equals OR", blank_bad, 0);
    check(blank_h_only && blank_v_only, "R11 blank from each source", blank_h_only + blank_v_only, 2);
  endtask

  task automatic t_clamp;
    do_reset();
    cfg_clamp_sel = 1'b0;
    hsync_i = 1'b1;
    repeat (3) tick();
    check(clamp_o == 0, "R1 hsync ignored when unselected", clamp_o, 0);
    clamp_i = 1'b1;
    tick();
    check(clamp_o == 0, "R1 clamp after one edge", clamp_o, 0);
    tick();
    check(clamp_o == 1, "R1 clamp after two edges", clamp_o, 1);
    clamp_i = 1'b0;
    repeat (3) tick();
    cfg_clamp_sel = 1'b1;
    tick();
    check(clamp_o == 1, "R1 hsync selected", clamp_o, 1);
    hsync_i = 1'b0;
    clamp_i = 1'b1;
    tick();
    check(clamp_o == 1, "R1 hsync after one edge", clamp_o, 1);
    tick();
    check(clamp_o == 0, "R1 hsync after two edges", clamp_o, 0);
    cfg_clamp_sel = 1'b0;
  endtask

  initial begin
    t_reset();
    t_hblank_cold();
    t_hadv_bounds();
    t_vblank_basic();
    t_vsync_long();
    t_vlines_clamp();
    t_restart();
    t_coincide();
    t_enables();
    t_blank_or();
    t_clamp();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule